// File: doc/BRIEF.md
# Texture Latency-Hiding Fragment Scheduler

This block runs a two-step shader over a pool of fragment contexts. The first step is a texture fetch. The second step is a dot product that needs the fetched texel. The scheduler does not wait on any single fetch. It loads a full batch of fragment addresses, one per context. It then sends the fetch request for context 0, context 1, and so on through the last context, without waiting for data. Only then does it return to context 0 to run the dot product. While later requests are being sent, earlier texels have time to come back from a slow texture cache.

Texels come back out of order on a return port. Each return carries the index of the context it belongs to. It is written into that context's slot in a register file, and a ready bit is set for that slot. The dependent pass walks the contexts in index order. If the texel for the current context is present, it multiplies it lane by lane with a constant coefficient vector, adds the products, and places the sum on a valid/ready result port. If the texel is missing, the pass waits on that context and a free-running stall counter goes up. A larger pool gives the cache more time per request, so this counter grows more slowly.

Top module: `tex_latency_sched`

## Requirements
- R1: After reset, frag_ready is 1, req_valid is 0, res_valid is 0 and stall_cycles is 0.
- R2: In the load phase frag_ready is 1. The k-th accepted fragment (frag_valid high at a rising edge while frag_ready) is bound to context k, for k from 0 to NUM_CTX-1. After the NUM_CTX-th acceptance, frag_ready goes low.
- R3: After loading, req_valid stays high while req_tag steps through 0 to NUM_CTX-1. req_tag advances only on a rising edge where req_ready is 1, and req_addr is the address loaded into context req_tag. Sending requests never waits for a texel return.
- R4: A return with ret_valid=1 stores ret_texel in context ret_tag, whatever order the returns arrive in. The result for a context uses exactly that texel.
- R5: After the last request is accepted, results are produced in context order 0 to NUM_CTX-1. res_data is the unsigned sum over the four 8-bit lanes of texel lane i times coef lane i, where lane i is bits [8i+7:8i].
- R6: During the dependent pass, every cycle in which the current context has no texel yet produces no result and adds one to stall_cycles. stall_cycles never decreases.
- R7: While res_valid is 1 and res_ready is 0, res_valid, res_tag and res_data hold their values.
- R8: frag_ready goes back to 1 only in the cycle after the last result of the batch has completed its handshake. It is never 1 while req_valid or res_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frag_valid | input | 1 | Fragment offered |
| frag_ready | output | 1 | Scheduler is loading a batch |
| frag_addr | input | ADDR_W | Texture address of the offered fragment |
| req_valid | output | 1 | Texture fetch request valid |
| req_ready | input | 1 | Cache accepts the request |
| req_addr | output | ADDR_W | Address to fetch |
| req_tag | output | IDX_W | Context index of the request |
| ret_valid | input | 1 | Texel return valid |
| ret_tag | input | IDX_W | Context index of the returned texel |
| ret_texel | input | LANES*LANE_W | Returned texel |
| coef | input | LANES*LANE_W | Constant vector for the dot product |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer accepts the result |
| res_tag | output | IDX_W | Context index of the result |
| res_data | output | RES_W | Dot product result |
| stall_cycles | output | STALL_W | Cycles spent waiting on a missing texel |

## Verification
Two things can happen in the same cycle. A texel return can be written for one context while the dependent pass reads and clears the ready bit of another context. A return can also arrive exactly in the cycle in which the pass is waiting on that same context. In that case the pass must still count the cycle as a stall and must fire on the next edge. Random return latencies, with short hits and long block-fill misses, together with random req_ready and res_ready back-pressure, create both cases many times per batch. A behavioural reference model, updated on every edge, judges each cycle by comparing every output against it. That covers the exact cycle of each result, the result's context and value, and the stall count.

// File: rtl/tls_pkg.sv
package tls_pkg;
  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_EXEC  = 2'd2,
    PH_DRAIN = 2'd3
  } phase_t;
endpackage

// File: rtl/tls_ctx_ram.sv
module tls_ctx_ram #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  // one write port, one asynchronous read port: maps to distributed RAM
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tls_dot.sv
module tls_dot #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OUT_W = 2 * LANE_W + ((LANES > 1) ? $clog2(LANES) : 1)
) (
  input  logic [LANES*LANE_W-1:0] vec_a,
  input  logic [LANES*LANE_W-1:0] vec_b,
  output logic [OUT_W-1:0]        sum
);
  logic [2*LANE_W-1:0] prod [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign prod[g] = vec_a[g*LANE_W +: LANE_W] * vec_b[g*LANE_W +: LANE_W];
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < LANES; i++) sum = sum + OUT_W'(prod[i]);
  end
endmodule

// File: rtl/tex_latency_sched.sv
module tex_latency_sched
  import tls_pkg::*;
#(
  parameter int NUM_CTX = 16,
  parameter int ADDR_W  = 16,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int STALL_W = 32,
  localparam int IDX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int TEXEL_W = LANES * LANE_W,
  localparam int RES_W   = 2 * LANE_W + ((LANES > 1) ? $clog2(LANES) : 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frag_valid,
  output logic               frag_ready,
  input  logic [ADDR_W-1:0]  frag_addr,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [IDX_W-1:0]   req_tag,
  input  logic               ret_valid,
  input  logic [IDX_W-1:0]   ret_tag,
  input  logic [TEXEL_W-1:0] ret_texel,
  input  logic [TEXEL_W-1:0] coef,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [IDX_W-1:0]   res_tag,
  output logic [RES_W-1:0]   res_data,
  output logic [STALL_W-1:0] stall_cycles
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CTX - 1);

  phase_t               phase;
  logic [IDX_W-1:0]     idx;
  logic [NUM_CTX-1:0]   texel_rdy;
  logic [TEXEL_W-1:0]   cur_texel;
  logic [RES_W-1:0]     dot_val;
  logic                 at_last;
  logic                 out_free;
  logic                 fire;
  logic                 waiting;
  logic                 load_we;

  assign at_last  = (idx == LAST_IDX);
  assign out_free = !res_valid || res_ready;
  assign fire     = (phase == PH_EXEC) && texel_rdy[idx] && out_free;
  assign waiting  = (phase == PH_EXEC) && !texel_rdy[idx];
  assign load_we  = (phase == PH_LOAD) && frag_valid;

  // per-context fragment address store
  tls_ctx_ram #(.DEPTH(NUM_CTX), .WIDTH(ADDR_W)) u_addr_ram (
    .clk   (clk),
    .we    (load_we),
    .waddr (idx),
    .wdata (frag_addr),
    .raddr (idx),
    .rdata (req_addr)
  );

  // per-context texel register file, written by tagged returns
  tls_ctx_ram #(.DEPTH(NUM_CTX), .WIDTH(TEXEL_W)) u_texel_ram (
    .clk   (clk),
    .we    (ret_valid),
    .waddr (ret_tag),
    .wdata (ret_texel),
    .raddr (idx),
    .rdata (cur_texel)
  );

  tls_dot #(.LANES(LANES), .LANE_W(LANE_W)) u_dot (
    .vec_a (cur_texel),
    .vec_b (coef),
    .sum   (dot_val)
  );

  // phase and context walker
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_LOAD;
      idx   <= '0;
    end else begin
      unique case (phase)
        PH_LOAD: if (frag_valid) begin
          if (at_last) begin
            phase <= PH_ISSUE;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_ISSUE: if (req_ready) begin
          if (at_last) begin
            phase <= PH_EXEC;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_EXEC: if (fire) begin
          if (at_last) begin
            phase <= PH_DRAIN;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_DRAIN: if (out_free) phase <= PH_LOAD;
        default: phase <= PH_LOAD;
      endcase
    end
  end

  // ready bits: set by a return, cleared when the context is consumed
  always_ff @(posedge clk) begin
    if (rst) begin
      texel_rdy <= '0;
    end else begin
      if (fire)      texel_rdy[idx]     <= 1'b0;
      if (ret_valid) texel_rdy[ret_tag] <= 1'b1;
    end
  end

  // result register with valid/ready handshake
  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_tag   <= '0;
      res_data  <= '0;
    end else if (fire) begin
      res_valid <= 1'b1;
      res_tag   <= idx;
      res_data  <= dot_val;
    end else if (res_valid && res_ready) begin
      res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          stall_cycles <= '0;
    else if (waiting) stall_cycles <= stall_cycles + 1'b1;
  end

  assign frag_ready = (phase == PH_LOAD);
  assign req_valid  = (phase == PH_ISSUE);
  assign req_tag    = idx;
endmodule

// File: rtl/tls_checker.sv
module tls_checker #(
  parameter int NUM_CTX = 16,
  parameter int IDX_W   = 4,
  parameter int ADDR_W  = 16,
  parameter int RES_W   = 18,
  parameter int STALL_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               frag_ready,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [IDX_W-1:0]   req_tag,
  input logic               res_valid,
  input logic               res_ready,
  input logic [IDX_W-1:0]   res_tag,
  input logic [RES_W-1:0]   res_data,
  input logic [STALL_W-1:0] stall_cycles
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CTX - 1);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_tag) && $stable(req_addr)); // R3

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_tag) && $stable(res_data)); // R7

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    frag_ready |-> !req_valid && !res_valid); // R8

  AST_STALL_MONO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> stall_cycles >= $past(stall_cycles)); // R6

  AST_RES_ORDER: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_ready && (res_tag != LAST_IDX)
      |=> !res_valid || (res_tag == IDX_W'($past(res_tag) + 1'b1))); // R5
endmodule

bind tex_latency_sched tls_checker #(
  .NUM_CTX (NUM_CTX),
  .IDX_W   (IDX_W),
  .ADDR_W  (ADDR_W),
  .RES_W   (RES_W),
  .STALL_W (STALL_W)
) u_tls_checker (
  .clk          (clk),
  .rst          (rst),
  .frag_ready   (frag_ready),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_addr     (req_addr),
  .req_tag      (req_tag),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .res_tag      (res_tag),
  .res_data     (res_data),
  .stall_cycles (stall_cycles)
);

// File: tb/tex_latency_sched_bench.sv
module tex_latency_sched_bench;
  localparam int N  = 16;
  localparam int AW = 16;
  localparam int IW = 4;
  localparam int TW = 32;
  localparam int RW = 18;
  localparam int SW = 32;
  localparam int NB = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frag_valid = 1'b0;
  logic          frag_ready;
  logic [AW-1:0] frag_addr = '0;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [IW-1:0] req_tag;
  logic          ret_valid = 1'b0;
  logic [IW-1:0] ret_tag = '0;
  logic [TW-1:0] ret_texel = '0;
  logic [TW-1:0] coef = 32'h01020304;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [IW-1:0] res_tag;
  logic [RW-1:0] res_data;
  logic [SW-1:0] stall_cycles;

  always #10 clk = ~clk;

  tex_latency_sched #(.NUM_CTX(N), .ADDR_W(AW)) u_tex_latency_sched (
    .clk(clk), .rst(rst),
    .frag_valid(frag_valid), .frag_ready(frag_ready), .frag_addr(frag_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_tag(req_tag),
    .ret_valid(ret_valid), .ret_tag(ret_tag), .ret_texel(ret_texel),
    .coef(coef),
    .res_valid(res_valid), .res_ready(res_ready), .res_tag(res_tag), .res_data(res_data),
    .stall_cycles(stall_cycles)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // ---------------- behavioural reference model ----------------
  int          m_phase;  // 0 load, 1 request, 2 dependent, 3 drain
  int          m_idx;
  int          m_addr [N];
  bit          m_have [N];
  logic [TW-1:0] m_tex [N];
  bit          m_rv;
  int          m_rtag;
  logic [RW-1:0] m_rdata;
  longint      m_stall;

  function automatic logic [RW-1:0] dotp(input logic [TW-1:0] t, input logic [TW-1:0] c);
    int s = 0;
    for (int i = 0; i < 4; i++) s += int'(t[8*i +: 8]) * int'(c[8*i +: 8]);
    return RW'(s);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_idx = 0; m_rv = 0; m_rtag = 0; m_rdata = '0; m_stall = 0;
      for (int i = 0; i < N; i++) m_have[i] = 0;
    end else begin
      bit fire, rv_old;
      rv_old = m_rv;
      fire = (m_phase == 2) && m_have[m_idx] && (!m_rv || res_ready);
      if (m_phase == 2 && !m_have[m_idx]) m_stall++;
      if (fire) begin
        m_rv = 1; m_rtag = m_idx; m_rdata = dotp(m_tex[m_idx], coef); m_have[m_idx] = 0;
      end else if (m_rv && res_ready) begin
        m_rv = 0;
      end
      case (m_phase)
        0: if (frag_valid) begin
             m_addr[m_idx] = int'(frag_addr);
             if (m_idx == N-1) begin m_phase = 1; m_idx = 0; end else m_idx++;
           end
        1: if (req_ready) begin
             if (m_idx == N-1) begin m_phase = 2; m_idx = 0; end else m_idx++;
           end
        2: if (fire) begin
             if (m_idx == N-1) begin m_phase = 3; m_idx = 0; end else m_idx++;
           end
        default: if (!rv_old || res_ready) m_phase = 0;
      endcase
      if (ret_valid) begin
        m_tex[ret_tag] = ret_texel; m_have[ret_tag] = 1;
      end
    end
  end

  // ---------------- texture cache stub ----------------
  int            p_due [N];
  bit            p_on  [N];
  logic [TW-1:0] p_tex [N];
  bit            seen_blk [int];

  task automatic chk(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic compare_all(input bit at_reset);
    string rf;
    rf = at_reset ? "R1" : ((m_phase == 0) ? "R2" : "R8");
    chk(rf, "frag_ready", 64'(frag_ready), 64'(m_phase == 0));
    chk(at_reset ? "R1" : "R3", "req_valid", 64'(req_valid), 64'(m_phase == 1));
    if (m_phase == 1) begin
      chk("R3", "req_tag", 64'(req_tag), 64'(m_idx));
      chk("R3", "req_addr", 64'(req_addr), 64'(m_addr[m_idx]));
    end
    chk(at_reset ? "R1" : "R7", "res_valid", 64'(res_valid), 64'(m_rv));
    if (m_rv) begin
      chk("R5", "res_tag", 64'(res_tag), 64'(m_rtag));
      chk("R4", "res_data", 64'(res_data), 64'(m_rdata));
    end
    chk(at_reset ? "R1" : "R6", "stall_cycles", 64'(stall_cycles), 64'(m_stall));
  endtask

  initial begin
    int cyc = 0;
    int done = 0;
    int batch = 0;
    int tail = 0;
    int base;
    for (int i = 0; i < N; i++) p_on[i] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare_all(1'b1);
    base = 0;
    while (tail < 10) begin
      int mode, pick;
      compare_all(1'b0);
      if (res_valid && res_ready) done++;
      batch = done / N;
      mode = batch % 3;
      if (done >= NB * N) tail++;
      // inputs for the next edge
      if (frag_ready) coef = {8'(batch * 37 + 1), 8'(255 - batch), 8'(batch * 11), 8'(200 + batch)};
      frag_valid = (done < NB * N) && ($urandom % 10 < 7);
      frag_addr  = AW'(base + int'($urandom % 64));
      if (frag_ready && frag_valid) base += 3;
      req_ready  = ($urandom % 8 != 0);
      res_ready  = (mode == 2) ? ($urandom % 2 == 1) : 1'b1;
      // pick the earliest due return
      pick = -1;
      for (int i = 0; i < N; i++)
        if (p_on[i] && p_due[i] <= cyc && (pick < 0 || p_due[i] < p_due[pick])) pick = i;
      if (pick >= 0) begin
        ret_valid = 1'b1; ret_tag = IW'(pick); ret_texel = p_tex[pick]; p_on[pick] = 0;
      end else begin
        ret_valid = 1'b0; ret_tag = '0; ret_texel = '0;
      end
      // schedule a return for a request accepted at the coming edge
      if (req_valid && req_ready) begin
        int blk, lat;
        blk = int'(req_addr) >> 3;
        if (mode == 1 || !seen_blk.exists(blk)) lat = 12 + int'($urandom % 32);
        else lat = 1 + int'($urandom % 3);
        seen_blk[blk] = 1;
        p_on[req_tag]  = 1;
        p_due[req_tag] = cyc + lat;
        p_tex[req_tag] = TW'(req_addr) * 32'h9E3779B1;
      end
      cyc++;
      if (cyc > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d results expected %0d", done, NB * N);
        break;
      end
      @(negedge clk);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule